// File: doc/BRIEF.md
# Data Memory Region Write-Protection Guard

This block guards program and erase operations on a partitioned data memory. It holds an 8-bit protection mask. Each mask bit covers one eighth of the partitioned space. A bit at 0 means its region is locked, and a bit at 1 means its region is open. While reset is held, the mask loads continuously from a configuration byte supplied on an input port, so it has no fixed reset constant.

Software updates the mask through a write port, and the operating mode filters each write. In normal mode a bit can only drop from 1 to 0, so protection only grows. In special mode every bit is freely writable. Writes that arrive while a command is still running are dropped.

The command sequencer presents each program, sector-erase or erase-all request to the block. In the same cycle it receives an accept or a reject. A reject also sets a sticky violation flag. While that flag is set, every further command is refused until software clears it.

Top module: `flash_region_guard`

## Requirements
- R1: While `rst_n` is low, `prot_mask` loads `cfg_byte` on each clock edge. The first edge after release shows that value, and `viol` shows 0.
- R2: In normal mode (`mode_special`=0), a write accepted on `wr_en` with `cmd_idle`=1 gives `prot_mask` the value old AND `wr_data` one clock later, so a bit can only change from 1 to 0.
- R3: In special mode (`mode_special`=1), an accepted write sets `prot_mask` to `wr_data` one clock later, in either direction per bit.
- R4: `prot_mask` keeps its value when `wr_en` is 0. It also keeps its value when a write arrives while `cmd_idle` is 0.
- R5: The partition holds 2^`part_log2` sectors of 2^`SECT_LOG` bytes. The target sector is `req_addr` >> `SECT_LOG`. Its region is sector >> max(`part_log2`-3, 0). A program (`req_kind`=00) or sector erase (`req_kind`=01) aimed at a region whose mask bit is 1 raises `req_ok` in the same cycle.
- R6: A program or sector erase aimed at a region whose mask bit is 0 raises `req_rej` in the same cycle and sets `viol` one clock later.
- R7: A program or sector erase whose sector is at or beyond 2^`part_log2` is rejected and sets `viol`.
- R8: When `part_log2` < 3, only the lowest 2^`part_log2` bits are in use. An erase-all (`req_kind`=1x) is accepted only when every used bit is 1 and every unused bit is 0. Otherwise it is rejected and sets `viol`.
- R9: `viol` stays set until a cycle with `viol_clr`=1. That cycle clears it on the next edge.
- R10: While `viol` is 1, every request is rejected, and the rejection does not itself keep the flag set.
- R11: `req_ok` and `req_rej` are never both high, and exactly one of them is high in each cycle with `req_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; loads the mask |
| cfg_byte | input | 8 | Configuration protection byte loaded during reset |
| cmd_idle | input | 1 | High when no command is running |
| mode_special | input | 1 | 1 = special mode, 0 = normal mode; sampled on each write |
| wr_en | input | 1 | Mask write strobe |
| wr_data | input | 8 | Mask write data |
| part_log2 | input | PLOG_W | log2 of the partition size in sectors |
| req_valid | input | 1 | Command request present |
| req_kind | input | 2 | 00 program, 01 sector erase, 1x erase all |
| req_addr | input | ADDR_W | Byte address targeted by the request |
| viol_clr | input | 1 | Write-1-to-clear strobe for the violation flag |
| req_ok | output | 1 | Request accepted (same cycle) |
| req_rej | output | 1 | Request rejected (same cycle) |
| viol | output | 1 | Sticky protection-violation flag |
| prot_mask | output | 8 | Current protection mask |

## Verification
The accept and reject outputs are combinational. They are due in the same cycle as the request, so the bench drives inputs just after a falling edge and samples them a nanosecond later. The mask and the violation flag pass through one register each, so they are due one clock after the stimulus. The bench compares them at the next falling edge against a behavioural model that it has already advanced by one step. A directed sequence hits each corner first, and a long weighted random run follows it. Both paths compare every output on every clock.

// File: rtl/fprot_pkg.sv
package fprot_pkg;
    localparam int NREG = 8;
    localparam int IDX_W = $clog2(NREG);

    typedef enum logic [1:0] {
        K_PROG     = 2'b00,
        K_ERS_SECT = 2'b01,
        K_ERS_ALL  = 2'b10,
        K_ERS_ALLX = 2'b11
    } req_kind_t;

    typedef struct packed {
        logic [NREG-1:0] prot;
        logic            viol;
    } guard_state_t;
endpackage

// File: rtl/fprot_wr_filter.sv
module fprot_wr_filter #(
    parameter int N = 8
) (
    input  logic [N-1:0] cur_q,
    input  logic [N-1:0] wr_data,
    input  logic         wr_en,
    input  logic         cmd_idle,
    input  logic         mode_special,
    output logic [N-1:0] nxt_d
);
    // Each bit gets its own filter; only special mode may raise a bit.
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            nxt_d[i] = cur_q[i];
            if (wr_en && cmd_idle) begin
                if (mode_special) nxt_d[i] = wr_data[i];
                else              nxt_d[i] = cur_q[i] & wr_data[i];
            end
        end
    end
endmodule

// File: rtl/fprot_region_map.sv
module fprot_region_map #(
    parameter int ADDR_W   = 20,
    parameter int SECT_LOG = 10,
    parameter int PLOG_W   = 3,
    parameter int N        = 8
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [PLOG_W-1:0]    part_log2,
    output logic [$clog2(N)-1:0] idx,
    output logic                 in_range,
    output logic [N-1:0]         used_mask
);
    localparam int SECT_W = ADDR_W - SECT_LOG;
    localparam int IW     = $clog2(N);

    logic [SECT_W-1:0] sector;
    logic [PLOG_W-1:0] rshift;
    logic              wide_part;

    always_comb begin
        sector    = addr[ADDR_W-1:SECT_LOG];
        wide_part = (32'(part_log2) >= IW);
        rshift    = '0;
        if (wide_part) rshift = part_log2 - PLOG_W'(IW);
        in_range  = ((sector >> part_log2) == '0);
        idx       = IW'(sector >> rshift);
    end

    // With fewer sectors than regions, regions past the partition are unused.
    for (genvar i = 0; i < N; i++) begin : g_used
        assign used_mask[i] = wide_part || (32'(i) < (32'd1 << part_log2));
    end
endmodule

// File: rtl/fprot_decide.sv
module fprot_decide #(
    parameter int N = 8
) (
    input  logic                 req_valid,
    input  fprot_pkg::req_kind_t req_kind,
    input  logic [$clog2(N)-1:0] idx,
    input  logic                 in_range,
    input  logic [N-1:0]         used_mask,
    input  logic [N-1:0]         prot_q,
    input  logic                 viol_q,
    output logic                 ok,
    output logic                 rej
);
    logic allowed;

    always_comb begin
        unique case (req_kind)
            fprot_pkg::K_PROG,
            fprot_pkg::K_ERS_SECT: allowed = in_range && prot_q[idx];
            default:               allowed = ((prot_q & used_mask) == used_mask)
                                             && ((prot_q & ~used_mask) == '0);
        endcase
        ok  = req_valid && !viol_q && allowed;
        rej = req_valid && !ok;
    end

    // R11: one verdict per request, never two
    always_comb begin
        p_one_verdict_r11: assert ($onehot0({ok, rej}) && ((ok || rej) == req_valid))
            else $error("p_one_verdict_r11");
    end
endmodule

// File: rtl/flash_region_guard.sv
module flash_region_guard #(
    parameter int ADDR_W   = 20,
    parameter int SECT_LOG = 10,
    parameter int PLOG_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cfg_byte,
    input  logic              cmd_idle,
    input  logic              mode_special,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic [PLOG_W-1:0] part_log2,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              viol_clr,
    output logic              req_ok,
    output logic              req_rej,
    output logic              viol,
    output logic [7:0]        prot_mask
);
    import fprot_pkg::*;

    guard_state_t     st_d, st_q;
    logic [NREG-1:0]  prot_nxt;
    logic [IDX_W-1:0] reg_idx;
    logic             tgt_in_range;
    logic [NREG-1:0]  used_mask;
    req_kind_t        kind;

    assign kind = req_kind_t'(req_kind);

    fprot_wr_filter #(.N(NREG)) u_wr (
        .cur_q        (st_q.prot),
        .wr_data      (wr_data),
        .wr_en        (wr_en),
        .cmd_idle     (cmd_idle),
        .mode_special (mode_special),
        .nxt_d        (prot_nxt)
    );

    fprot_region_map #(
        .ADDR_W(ADDR_W), .SECT_LOG(SECT_LOG), .PLOG_W(PLOG_W), .N(NREG)
    ) u_map (
        .addr      (req_addr),
        .part_log2 (part_log2),
        .idx       (reg_idx),
        .in_range  (tgt_in_range),
        .used_mask (used_mask)
    );

    fprot_decide #(.N(NREG)) u_dec (
        .req_valid (req_valid),
        .req_kind  (kind),
        .idx       (reg_idx),
        .in_range  (tgt_in_range),
        .used_mask (used_mask),
        .prot_q    (st_q.prot),
        .viol_q    (st_q.viol),
        .ok        (req_ok),
        .rej       (req_rej)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prot = prot_nxt;
        // a refusal caused only by the flag itself is not a new violation
        st_d.viol = (st_q.viol && !viol_clr) || (req_rej && !st_q.viol);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.prot <= cfg_byte;
            st_q.viol <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prot_mask = st_q.prot;
    assign viol      = st_q.viol;

    // R2: normal-mode writes can only clear bits
    p_normal_and_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd_idle && !mode_special) |=> (prot_mask == ($past(prot_mask) & $past(wr_data))));
    // R3: special-mode writes land unchanged
    p_special_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd_idle && mode_special) |=> (prot_mask == $past(wr_data)));
    // R4: no accepted write, no change
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && cmd_idle) |=> $stable(prot_mask));
    // R6: a fresh refusal raises the flag
    p_rej_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rej && !viol) |=> viol);
    // R9: flag is sticky until cleared, and the clear takes effect
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (viol && !viol_clr) |=> viol);
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (viol && viol_clr) |=> !viol);
    // R10: nothing launches while the flag is up
    p_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> !req_ok);
endmodule

// File: tb/sim_flash_region_guard.sv
`timescale 1ns/1ps
module sim_flash_region_guard;
    localparam int ADDR_W = 20, SECT_LOG = 10, PLOG_W = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, cmd_idle = 1'b1, mode_special = 1'b0, wr_en = 1'b0;
    logic [7:0] cfg_byte = 8'hA5, wr_data = '0;
    logic [PLOG_W-1:0] part_log2 = 3'd7;
    logic req_valid = 1'b0, viol_clr = 1'b0;
    logic [1:0] req_kind = 2'b00;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_ok, req_rej, viol;
    logic [7:0] prot_mask;

    flash_region_guard #(.ADDR_W(ADDR_W), .SECT_LOG(SECT_LOG), .PLOG_W(PLOG_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte), .cmd_idle(cmd_idle),
        .mode_special(mode_special), .wr_en(wr_en), .wr_data(wr_data),
        .part_log2(part_log2), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .viol_clr(viol_clr), .req_ok(req_ok),
        .req_rej(req_rej), .viol(viol), .prot_mask(prot_mask)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;
    logic [7:0] m_prot;
    bit m_viol;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int used_count();
        return (part_log2 >= 3) ? 8 : (1 << part_log2);
    endfunction

    function automatic bit exp_allowed(output string tag);
        int sector, rsh, region, u;
        logic [7:0] um;
        sector = int'(req_addr >> SECT_LOG);
        u = used_count();
        um = 8'((1 << u) - 1);
        if (req_kind[1]) begin
            tag = "R8";
            return ((m_prot & um) == um) && ((m_prot & ~um) == 8'h00);
        end
        if (sector >= (1 << part_log2)) begin
            tag = "R7";
            return 1'b0;
        end
        rsh = (part_log2 >= 3) ? int'(part_log2) - 3 : 0;
        region = sector >> rsh;
        tag = m_prot[region] ? "R5" : "R6";
        return m_prot[region];
    endfunction

    // inputs already driven after a falling edge; ends at the next falling edge
    task automatic step();
        string vtag, wtag;
        bit allow, e_ok, e_rej;
        #1;
        allow = exp_allowed(vtag);
        if (m_viol) vtag = "R10";
        e_ok  = req_valid && !m_viol && allow;
        e_rej = req_valid && !e_ok;
        chk({vtag, " ok"}, req_ok, e_ok);
        chk({"R11 ", vtag, " rej"}, req_rej, e_rej);
        wtag = "R4";
        if (wr_en && cmd_idle) begin
            wtag = mode_special ? "R3" : "R2";
            m_prot = mode_special ? wr_data : (m_prot & wr_data);
        end
        m_viol = (m_viol && !viol_clr) || (e_rej && !m_viol);
        @(negedge clk);
        chk({wtag, " mask"}, prot_mask, m_prot);
        chk("R9 viol", viol, m_viol);
    endtask

    task automatic quiet();
        wr_en = 0; req_valid = 0; viol_clr = 0; cmd_idle = 1; mode_special = 0;
    endtask

    task automatic req(logic [1:0] k, int sector);
        quiet(); req_valid = 1; req_kind = k;
        req_addr = ADDR_W'(sector << SECT_LOG) | ADDR_W'(sector * 37 % 1024);
        step();
    endtask

    task automatic wr(bit sp, logic [7:0] d, bit idle);
        quiet(); wr_en = 1; mode_special = sp; wr_data = d; cmd_idle = idle;
        step();
    endtask

    task automatic clr();
        quiet(); viol_clr = 1; step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_prot = 8'hA5; m_viol = 0;
        @(negedge clk);
        chk("R1 mask", prot_mask, 8'hA5);
        chk("R1 viol", viol, 1'b0);
        // 128 sectors: 16 sectors per region
        part_log2 = 3'd7;
        req(2'b00, 0);     // R5 region0 open
        req(2'b01, 40);    // R5 region2 open
        req(2'b00, 16);    // R6 region1 locked
        req(2'b00, 0);     // R10 blocked while flagged
        clr();             // R9
        wr(0, 8'hFF, 1);   // R2 no rise in normal mode
        wr(0, 8'h7F, 1);   // R2 clears bit7
        wr(1, 8'hFF, 0);   // R4 busy write dropped
        wr(1, 8'hFF, 1);   // R3 free write
        req(2'b10, 0);     // R8 erase all, all open
        part_log2 = 3'd2;  // 4 sectors, 4 used bits
        req(2'b10, 0);     // R8 unused bits set -> reject
        clr();
        wr(1, 8'h0F, 1);
        req(2'b11, 0);     // R8 accepted
        req(2'b00, 3);     // R5 one sector per region
        req(2'b00, 4);     // R7 beyond partition
        clr();
        wr(1, 8'h0D, 1);
        req(2'b01, 1);     // R6 region1 locked in small partition
        clr();
        for (int i = 0; i < 4000; i++) begin
            quiet();
            cmd_idle     = ($urandom_range(0, 4) != 0);
            mode_special = $urandom_range(0, 1);
            wr_en        = ($urandom_range(0, 3) == 0);
            wr_data      = 8'($urandom);
            viol_clr     = ($urandom_range(0, 3) == 0);
            part_log2    = PLOG_W'($urandom_range(0, 7));
            req_valid    = $urandom_range(0, 1);
            req_kind     = 2'($urandom_range(0, 3));
            req_addr     = ADDR_W'(($urandom_range(0, (2 << part_log2) - 1) << SECT_LOG)
                                   | $urandom_range(0, 1023));
            step();
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog all-reqs actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule